// File: doc/BRIEF.md
# Coprocessor Load/Store Beat Sequencer

This block sits between a 32-bit memory data path and a bank of 64-bit coprocessor registers. It handles coprocessor load and store instructions. The host presents one phase per cycle: a data beat or a non-data phase. A load beat carries a word to be written into a register. A store beat returns a word read from a register. The block answers in the same cycle. It either asks the host to step the address and send another beat, or it reports that the instruction is complete.

A transfer is one word or two words, chosen by one instruction bit. For a two-word transfer, the big-endian input decides which register half each beat uses. For a one-word transfer, a mode input decides how the register is viewed. In float form, the word sits in the upper half. In integer form, it sits in the lower half, and loads sign-extend it across the full register. The block holds the register bank. An abort input drops a two-word transfer partway through.

A small state machine tracks the beats. It has two states:
- `ST_FIRST`: waiting for the first beat, or idle.
- `ST_SECOND`: waiting for the second beat of a two-word transfer.

Its transitions are:
- T_SINGLE: `ST_FIRST` to `ST_FIRST` on a one-word beat.
- T_OPEN: `ST_FIRST` to `ST_SECOND` on the first beat of a two-word transfer.
- T_CLOSE: `ST_SECOND` to `ST_FIRST` on the second beat.
- T_FLUSH: any state to `ST_FIRST` on a non-data phase.
- T_ABORT: any state to `ST_FIRST` on abort.
- T_HOLD: the state is kept when there is no request.

Top module: `cop_ldst_seq`

## Requirements
- R1: After reset the sequencer is in `ST_FIRST`, and every register reads as zero.
- R2: A data beat in `ST_FIRST` with instruction bit 22 clear is a one-word transfer. It is answered with `resp_done=1` and `resp_inc=0`.
- R3: With instruction bit 22 set, the first data beat is answered with `resp_inc=1` and `resp_done=0`. The next data beat is answered with `resp_done=1` and `resp_inc=0`. Cycles without a request or abort keep the sequencer waiting for that second beat.
- R4: A non-data phase (`req_data_phase=0`) is answered with `resp_done=1` and returns the beat count to zero. The next data beat of a two-word transfer is therefore a first beat again.
- R5: On a two-word load with `big_endian=1`, the first beat writes bits 63:32 and the second beat writes bits 31:0. With `big_endian=0`, the first beat writes bits 31:0 and the second writes bits 63:32.
- R6: On a two-word store, `rd_data` follows the same half order as R5.
- R7: A one-word load with `float_mode=1` writes bits 63:32 only. Bits 31:0 keep their value.
- R8: A one-word load with `float_mode=0` writes the word to bits 31:0. Bits 63:32 are filled with copies of word bit 31.
- R9: A one-word store returns bits 63:32 when `float_mode=1` and bits 31:0 when `float_mode=0`. `rd_data` is zero in any cycle that is not an accepted store data beat.
- R10: The register index is taken from instruction bits 15:12 only. Other registers are left unchanged.
- R11: `abort` suppresses any write and any response in its cycle, and returns the sequencer to `ST_FIRST`.
- R12: A load writes its register on the clock edge that ends its beat cycle. A store in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A phase is presented this cycle |
| req_data_phase | input | 1 | 1: data beat. 0: non-data phase |
| req_store | input | 1 | 1: store (register to bus). 0: load |
| req_instr | input | 32 | Instruction word. Bit 22 selects two words; bits 15:12 give the register index |
| big_endian | input | 1 | Half order for two-word transfers |
| float_mode | input | 1 | One-word register view. 1: float. 0: integer |
| abort | input | 1 | Cancels the transfer in progress |
| wr_data | input | 32 | Load data word |
| rd_data | output | 32 | Store data word |
| resp_valid | output | 1 | A response is given this cycle |
| resp_inc | output | 1 | Step the address and send another beat |
| resp_done | output | 1 | Instruction complete |

## Verification
The bench uses the default parameters. These are a 32-bit word, sixteen registers, the index field at bits 15:12 and the width bit at 22. So the highest index, 15, and the word sign bit 31 are both reachable. The sign-extension case is covered with both sign values. Both half orders are tested for loads and for stores. Each of the two cancelling events is placed between the beats of a two-word transfer.

// File: rtl/cop_ldst_pkg.sv
package cop_ldst_pkg;

    typedef enum logic [0:0] {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } beat_state_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic sext;
        logic rd_hi;
    } lane_ctl_t;

endpackage

// File: rtl/cop_beat_ctrl.sv
module cop_beat_ctrl
    import cop_ldst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_data_phase,
    input  logic        wide,
    input  logic        abort,
    output beat_state_e state,
    output logic        resp_valid,
    output logic        resp_inc,
    output logic        resp_done,
    output logic        data_fire
);

    beat_state_e state_q;
    beat_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        resp_valid = 1'b0;
        resp_inc   = 1'b0;
        resp_done  = 1'b0;
        data_fire  = 1'b0;
        if (abort) begin
            state_d = ST_FIRST;
        end else if (req_valid) begin
            resp_valid = 1'b1;
            if (!req_data_phase) begin
                resp_done = 1'b1;
                state_d   = ST_FIRST;
            end else begin
                data_fire = 1'b1;
                unique case (state_q)
                    ST_FIRST: begin
                        if (wide) begin
                            resp_inc = 1'b1;
                            state_d  = ST_SECOND;
                        end else begin
                            resp_done = 1'b1;
                        end
                    end
                    ST_SECOND: begin
                        resp_done = 1'b1;
                        state_d   = ST_FIRST;
                    end
                endcase
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/cop_lane_steer.sv
module cop_lane_steer
    import cop_ldst_pkg::*;
(
    input  beat_state_e state,
    input  logic        wide,
    input  logic        store,
    input  logic        big_endian,
    input  logic        float_mode,
    input  logic        fire,
    output lane_ctl_t   ctl
);

    logic hi_sel;
    logic wr_en;

    always_comb begin
        hi_sel = (state == ST_FIRST) ? big_endian : !big_endian;
        wr_en  = fire && !store;
        ctl    = '0;
        if (wide) begin
            ctl.rd_hi = hi_sel;
            ctl.wr_hi = wr_en && hi_sel;
            ctl.wr_lo = wr_en && !hi_sel;
        end else begin
            ctl.rd_hi = float_mode;
            ctl.wr_hi = wr_en;
            ctl.wr_lo = wr_en && !float_mode;
            ctl.sext  = !float_mode;
        end
    end

endmodule

// File: rtl/cop_regfile.sv
module cop_regfile #(
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int REG_W   = 2 * WORD_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              sext,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi
);

    logic [REG_W-1:0]  ent_bus [NUM_REGS];
    logic [WORD_W-1:0] hi_word;

    assign hi_word = sext ? {WORD_W{wdata[WORD_W-1]}} : wdata;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        logic [REG_W-1:0] ent_q;
        logic             sel;
        assign sel = (idx == IDX_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (sel) begin
                if (wr_lo) ent_q[WORD_W-1:0]     <= wdata;
                if (wr_hi) ent_q[REG_W-1:WORD_W] <= hi_word;
            end
        end
        assign ent_bus[g] = ent_q;
    end

    assign rd_lo = ent_bus[idx][WORD_W-1:0];
    assign rd_hi = ent_bus[idx][REG_W-1:WORD_W];

endmodule

// File: rtl/cop_ldst_seq.sv
module cop_ldst_seq
    import cop_ldst_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int INSTR_W  = 32,
    parameter int IDX_LSB  = 12,
    parameter int WIDE_BIT = 22,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_data_phase,
    input  logic               req_store,
    input  logic [INSTR_W-1:0] req_instr,
    input  logic               big_endian,
    input  logic               float_mode,
    input  logic               abort,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_data,
    output logic               resp_valid,
    output logic               resp_inc,
    output logic               resp_done
);

    beat_state_e       state;
    lane_ctl_t         ctl;
    logic              wide;
    logic              data_fire;
    logic              in_second;
    logic [IDX_W-1:0]  reg_idx;
    logic [WORD_W-1:0] half_lo;
    logic [WORD_W-1:0] half_hi;
    logic              instr_unused;

    assign wide         = req_instr[WIDE_BIT];
    assign reg_idx      = req_instr[IDX_LSB +: IDX_W];
    assign instr_unused = ^req_instr;
    assign in_second    = (state == ST_SECOND);

    cop_beat_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_data_phase (req_data_phase),
        .wide           (wide),
        .abort          (abort),
        .state          (state),
        .resp_valid     (resp_valid),
        .resp_inc       (resp_inc),
        .resp_done      (resp_done),
        .data_fire      (data_fire)
    );

    cop_lane_steer u_steer (
        .state      (state),
        .wide       (wide),
        .store      (req_store),
        .big_endian (big_endian),
        .float_mode (float_mode),
        .fire       (data_fire),
        .ctl        (ctl)
    );

    cop_regfile #(
        .WORD_W   (WORD_W),
        .NUM_REGS (NUM_REGS)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (reg_idx),
        .wr_lo (ctl.wr_lo),
        .wr_hi (ctl.wr_hi),
        .sext  (ctl.sext),
        .wdata (wr_data),
        .rd_lo (half_lo),
        .rd_hi (half_hi)
    );

    always_comb begin
        rd_data = '0;
        if (data_fire && req_store) rd_data = ctl.rd_hi ? half_hi : half_lo;
    end

endmodule

// File: rtl/cop_ldst_seq_chk.sv
module cop_ldst_seq_chk #(
    parameter int WORD_W   = 32,
    parameter int INSTR_W  = 32,
    parameter int WIDE_BIT = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_data_phase,
    input logic               req_store,
    input logic [INSTR_W-1:0] req_instr,
    input logic               abort,
    input logic [WORD_W-1:0]  rd_data,
    input logic               resp_valid,
    input logic               resp_inc,
    input logic               resp_done,
    input logic               in_second
);

    assert_open_to_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_inc |=> in_second);

    assert_second_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_second && req_valid && req_data_phase && !abort) |-> (resp_done && !resp_inc));

    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !abort) |=> (in_second == $past(in_second)));

    assert_narrow_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_second && req_valid && req_data_phase && !req_instr[WIDE_BIT] && !abort)
            |-> (resp_done && !resp_inc));

    assert_flush_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_data_phase && !abort) |-> (resp_done && !resp_inc));

    assert_flush_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_data_phase && !abort) |=> !in_second);

    assert_abort_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !resp_valid);

    assert_abort_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !in_second);

    assert_store_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_data_phase && req_store && !abort) |-> (rd_data == '0));

endmodule

bind cop_ldst_seq cop_ldst_seq_chk #(
    .WORD_W   (WORD_W),
    .INSTR_W  (INSTR_W),
    .WIDE_BIT (WIDE_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_data_phase (req_data_phase),
    .req_store      (req_store),
    .req_instr      (req_instr),
    .abort          (abort),
    .rd_data        (rd_data),
    .resp_valid     (resp_valid),
    .resp_inc       (resp_inc),
    .resp_done      (resp_done),
    .in_second      (in_second)
);

// File: tb/cop_ldst_seq_test.sv
`timescale 1ns/1ps
module cop_ldst_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_data_phase = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] req_instr = '0;
    logic        big_endian = 1'b0;
    logic        float_mode = 1'b0;
    logic        abort = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        resp_valid;
    logic        resp_inc;
    logic        resp_done;

    always #4 clk = ~clk;

    cop_ldst_seq uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_data_phase (req_data_phase),
        .req_store      (req_store),
        .req_instr      (req_instr),
        .big_endian     (big_endian),
        .float_mode     (float_mode),
        .abort          (abort),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .resp_valid     (resp_valid),
        .resp_inc       (resp_inc),
        .resp_done      (resp_done)
    );

    typedef struct {
        bit          chk_rd;
        logic [31:0] rd;
        bit          v;
        bit          inc;
        bit          done;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [63:0] mdl [16];
    int          mcnt = 0;

    // Monitor: pops expectations and compares, mid-cycle after inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if ({resp_valid, resp_inc, resp_done} !== {e.v, e.inc, e.done}) begin
                    n_fail++;
                    $display("FAIL %s: valid/inc/done actual %b%b%b expected %b%b%b",
                             e.tag, resp_valid, resp_inc, resp_done, e.v, e.inc, e.done);
                end
                n_checks++;
                if (e.chk_rd && rd_data !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: rd_data actual %h expected %h", e.tag, rd_data, e.rd);
                end
            end
        end
    end

    // Driver: presents one phase and pushes the expected response.
    task automatic phase(input bit dp, input bit st, input bit wide, input int idx,
                         input bit be, input bit fm, input logic [31:0] wd,
                         input bit ab, input string tag);
        exp_t e;
        bit   hi;
        @(negedge clk);
        req_valid      = !ab;
        req_data_phase = dp;
        req_store      = st;
        req_instr      = '0;
        req_instr[31:28] = 4'hE;
        req_instr[22]    = wide;
        req_instr[19:16] = ~idx[3:0];
        req_instr[15:12] = idx[3:0];
        req_instr[3:0]   = idx[3:0] + 4'd1;
        big_endian = be;
        float_mode = fm;
        abort      = ab;
        wr_data    = wd;
        e.tag = tag;
        e.chk_rd = 1'b1;
        e.rd = '0;
        e.v = !ab;
        e.inc = 1'b0;
        e.done = 1'b0;
        if (ab) begin
            mcnt = 0;
        end else if (!dp) begin
            e.done = 1'b1;
            mcnt = 0;
        end else if (wide) begin
            hi = (mcnt == 0) ? be : !be;
            e.inc  = (mcnt == 0);
            e.done = (mcnt != 0);
            if (st) e.rd = hi ? mdl[idx][63:32] : mdl[idx][31:0];
            else if (hi) mdl[idx][63:32] = wd;
            else mdl[idx][31:0] = wd;
            mcnt = (mcnt == 0) ? 1 : 0;
        end else begin
            e.done = 1'b1;
            if (st) e.rd = fm ? mdl[idx][63:32] : mdl[idx][31:0];
            else if (fm) mdl[idx][63:32] = wd;
            else mdl[idx] = {{32{wd[31]}}, wd};
        end
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        abort     = 1'b0;
        e.tag = tag; e.chk_rd = 1'b1; e.rd = '0; e.v = 0; e.inc = 0; e.done = 0;
        sb.push_back(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: registers read zero after reset
        phase(1, 1, 0, 0, 0, 0, 0, 0, "R1 reg0 int");
        phase(1, 1, 0, 15, 0, 1, 0, 0, "R1 reg15 float");
        phase(1, 1, 1, 15, 1, 0, 0, 0, "R1 wide first");
        phase(1, 1, 1, 15, 1, 0, 0, 0, "R1 wide second");

        // R8 negative sign extension, R12 immediate readback
        phase(1, 0, 0, 3, 0, 0, 32'h8000_0001, 0, "R8 int load neg");
        phase(1, 1, 0, 3, 0, 1, 0, 0, "R8 upper ones R12");
        // R7 float load keeps lower half
        phase(1, 0, 0, 3, 0, 1, 32'h1234_5678, 0, "R7 float load");
        phase(1, 1, 0, 3, 0, 0, 0, 0, "R7 lower kept R9");
        phase(1, 1, 0, 3, 0, 1, 0, 0, "R9 float store upper");
        // R8 positive sign extension, seen through a wide store
        phase(1, 0, 0, 4, 0, 0, 32'h7FFF_FFFF, 0, "R8 int load pos");
        phase(1, 1, 1, 4, 1, 0, 0, 0, "R8 pos upper R6");
        phase(1, 1, 1, 4, 1, 0, 0, 0, "R8 pos lower R6");

        // R5/R3 two-word loads in both orders
        phase(1, 0, 1, 5, 1, 0, 32'hAAAA_0001, 0, "R5 be first R3");
        phase(1, 0, 1, 5, 1, 0, 32'hBBBB_0002, 0, "R5 be second R3");
        phase(1, 1, 0, 5, 0, 1, 0, 0, "R5 be upper");
        phase(1, 1, 0, 5, 0, 0, 0, 0, "R5 be lower");
        phase(1, 0, 1, 6, 0, 0, 32'hCCCC_0003, 0, "R5 le first");
        idle("R3 wait idle");
        phase(1, 0, 1, 6, 0, 0, 32'hDDDD_0004, 0, "R5 le second R3");
        phase(1, 1, 0, 6, 0, 1, 0, 0, "R5 le upper");
        phase(1, 1, 0, 6, 0, 0, 0, 0, "R5 le lower");

        // R6 two-word stores in both orders
        phase(1, 1, 1, 5, 1, 0, 0, 0, "R6 be first");
        phase(1, 1, 1, 5, 1, 0, 0, 0, "R6 be second");
        phase(1, 1, 1, 6, 0, 0, 0, 0, "R6 le first");
        phase(1, 1, 1, 6, 0, 0, 0, 0, "R6 le second");

        // R4 non-data phase between beats restarts the count
        phase(1, 0, 1, 7, 1, 0, 32'h1111_1111, 0, "R4 first beat");
        phase(0, 0, 1, 7, 1, 0, 0, 0, "R4 flush");
        phase(1, 0, 1, 7, 1, 0, 32'h2222_2222, 0, "R4 restart first");
        phase(1, 0, 1, 7, 1, 0, 32'h3333_3333, 0, "R4 second");
        phase(1, 1, 1, 7, 1, 0, 0, 0, "R4 read upper");
        phase(1, 1, 1, 7, 1, 0, 0, 0, "R4 read lower");

        // R11 abort between beats, and abort suppressing a write
        phase(1, 0, 1, 8, 0, 0, 32'h4444_4444, 0, "R11 first beat");
        phase(1, 0, 1, 8, 0, 0, 32'h5555_5555, 1, "R11 abort");
        phase(1, 0, 1, 8, 0, 0, 32'h6666_6666, 0, "R11 restart first");
        phase(1, 0, 1, 8, 0, 0, 32'h7777_7777, 0, "R11 second");
        phase(1, 1, 0, 8, 0, 0, 0, 0, "R11 lower value");
        phase(1, 1, 0, 8, 0, 1, 0, 0, "R11 upper value");
        phase(1, 0, 0, 9, 0, 0, 32'h9999_9999, 1, "R11 aborted load");
        phase(1, 1, 0, 9, 0, 0, 0, 0, "R11 no write");

        // R10 index field only; neighbours untouched
        phase(1, 0, 0, 10, 0, 0, 32'h0BAD_F00D, 0, "R10 load reg10");
        phase(1, 1, 0, 10, 0, 0, 0, 0, "R10 read reg10");
        phase(1, 1, 0, 11, 0, 0, 0, 0, "R10 reg11 untouched");
        phase(1, 1, 0, 5, 0, 1, 0, 0, "R10 reg5 untouched");
        // R2 narrow after wide completed
        phase(1, 0, 0, 12, 1, 1, 32'hFEED_BEEF, 0, "R2 narrow done");
        idle("R9 idle quiet");
        idle("R9 idle quiet 2");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule